// File: doc/BRIEF.md
# Pipeline Hazard and Branch Control Unit

This block is the stall, bypass and squash controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). The branch condition and target are both settled in decode. The datapath gives the unit the register fields, the write-enable and load flags of the instructions in each later stage, and the branch outcome from decode. The unit returns the enables and selects that the datapath needs: hold or advance the program counter and the fetch/decode register, insert a bubble into execute, squash the instruction in fetch, choose the next-PC source, and steer the execute and branch-compare operand multiplexers.

Two run-time inputs set the policy. `fwd_en` chooses between full bypassing and a mode with no bypassing. In the mode with no bypassing, the register file writes in the first half of a cycle and reads in the second half, so a producer that has reached write-back no longer causes a stall. `br_policy` selects one of three branch policies: always squash the next fetch, predict not-taken, or predict taken.

A small state machine controls branch redirection. It has two states. `ST_RUN` is normal flow. `ST_VERIFY` lasts one cycle and follows a predict-taken redirect. Transitions: `ST_RUN`→`ST_VERIFY` when a branch resolves in decode without a stall under the predict-taken policy. `ST_VERIFY`→`ST_RUN` always, after one cycle. In every other case the machine stays in `ST_RUN`.

Top module: `hzc_top`

## Requirements
- R1: After reset the unit is in `ST_RUN`. With no dependence and no branch in decode, `pc_we`=1, `ifid_we`=1, `idex_bubble`=0, `ifid_flush`=0 and `pc_sel`=0 (sequential).
- R2: When `fwd_en`=0, the unit stalls if a used decode source equals the nonzero destination of a register-writing instruction in execute or memory. A stall means `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1. A match against the write-back destination causes no stall.
- R3: When `fwd_en`=1 and decode holds a non-branch, the unit stalls only if execute holds a load (`ex_mem_rd`=1) whose destination a used decode source reads. An ALU producer in execute causes no stall.
- R4: When `fwd_en`=1 and decode holds a branch, the unit stalls if any register writer in execute or a load in memory produces a source of the branch. If an ALU writer in memory produces a source, there is no stall, and `br_fwd_a` or `br_fwd_b` (for source 1 or source 2) is set to 1 to take the memory-stage result.
- R5: Register 0 never counts as a dependence for stalls or forwarding.
- R6: The execute operand selects `fwd_a` and `fwd_b` use these codes: 0 = register file, 1 = execute/memory latch, 2 = memory/write-back latch. The memory-stage match has priority over the write-back match. Both selects are 0 when `fwd_en`=0.
- R7: With `br_policy`=0 (squash), or the unused code 3, a branch that resolves in decode without a stall sets `ifid_flush`=1. It also sets `pc_sel`=1 (target) if taken or `pc_sel`=2 (fall-through) if not taken.
- R8: With `br_policy`=1 (predict not-taken), a not-taken branch leaves the flow untouched. A taken branch sets `ifid_flush`=1 and `pc_sel`=1.
- R9: With `br_policy`=2 (predict taken), the cycle in which the branch resolves sets `ifid_flush`=1 and `pc_sel`=1. In the next cycle, if the outcome was not taken, the unit sets `ifid_flush`=1 and `pc_sel`=2. If the outcome was taken, that next cycle runs normally.
- R10: While a branch in decode is stalled, the unit takes no branch action: `ifid_flush`=0 and `pc_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1 = full bypassing, 0 = no bypassing |
| br_policy | input | 2 | 0 squash, 1 predict not-taken, 2 predict taken, 3 squash |
| id_rs1 | input | RW | Decode source register 1 |
| id_rs2 | input | RW | Decode source register 2 |
| id_use_rs1 | input | 1 | Decode instruction reads source 1 |
| id_use_rs2 | input | 1 | Decode instruction reads source 2 |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_br_taken | input | 1 | Branch outcome evaluated in decode |
| ex_rs1 | input | RW | Execute source register 1 |
| ex_rs2 | input | RW | Execute source register 2 |
| ex_rd | input | RW | Execute destination register |
| ex_reg_we | input | 1 | Execute instruction writes a register |
| ex_mem_rd | input | 1 | Execute instruction is a load |
| mem_rd | input | RW | Memory-stage destination register |
| mem_reg_we | input | 1 | Memory-stage instruction writes a register |
| mem_mem_rd | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | RW | Write-back destination register |
| wb_reg_we | input | 1 | Write-back instruction writes a register |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode latch write enable |
| ifid_flush | output | 1 | Squash the instruction in fetch |
| idex_bubble | output | 1 | Insert a bubble into execute |
| pc_sel | output | 2 | 0 sequential, 1 branch target, 2 fall-through |
| fwd_a | output | 2 | Execute operand A source |
| fwd_b | output | 2 | Execute operand B source |
| br_fwd_a | output | 1 | Branch compare source 1 from memory-stage result |
| br_fwd_b | output | 1 | Branch compare source 2 from memory-stage result |

## Verification
If the state machine enters `ST_VERIFY` wrongly, or never leaves it, the fault shows at the ports one cycle after the branch. There it appears as a missing or extra squash with `pc_sel`=2 on the cycle after resolution. A wrongly latched branch outcome shows in that same cycle. A fault in dependence detection shows in the same cycle as the stimulus, as `pc_we` and `idex_bubble` taking the wrong values. A fault in bypass priority shows at once on `fwd_a` and `fwd_b`. The predict-taken sequences therefore compare two consecutive cycles, and every other case compares the cycle in which the stimulus is applied.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } opnd_src_e;

    typedef enum logic [1:0] {
        NXT_SEQ      = 2'd0,
        NXT_TARGET   = 2'd1,
        NXT_FALLTHRU = 2'd2
    } next_pc_e;

    typedef enum logic [1:0] {
        POL_FLUSH     = 2'd0,
        POL_NOT_TAKEN = 2'd1,
        POL_TAKEN     = 2'd2,
        POL_RSVD      = 2'd3
    } br_pol_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_VERIFY = 1'b1
    } br_state_e;
endpackage

// File: rtl/hzc_stall.sv
module hzc_stall #(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fwd_en,
    input  logic [NSRC-1:0][RW-1:0]   id_src,
    input  logic [NSRC-1:0]           id_use,
    input  logic                      id_is_branch,
    input  logic [RW-1:0]             ex_rd,
    input  logic                      ex_reg_we,
    input  logic                      ex_mem_rd,
    input  logic [RW-1:0]             mem_rd,
    input  logic                      mem_reg_we,
    input  logic                      mem_mem_rd,
    output logic                      stall,
    output logic [NSRC-1:0]           br_fwd
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] ex_hit;
    logic [NSRC-1:0] mem_hit;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign ex_hit[k]  = id_use[k] && ex_reg_we  && (ex_rd  != ZERO_REG) && (ex_rd  == id_src[k]);
        assign mem_hit[k] = id_use[k] && mem_reg_we && (mem_rd != ZERO_REG) && (mem_rd == id_src[k]);
        assign br_fwd[k]  = fwd_en && id_is_branch && mem_hit[k] && !mem_mem_rd;
    end

    always_comb begin
        if (!fwd_en) begin
            stall = (|ex_hit) || (|mem_hit);
        end else if (id_is_branch) begin
            stall = (|ex_hit) || ((|mem_hit) && mem_mem_rd);
        end else begin
            stall = (|ex_hit) && ex_mem_rd;
        end
    end

    // R5: register 0 as the only destination never stalls
    a_r5_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == ZERO_REG && mem_rd == ZERO_REG) |-> !stall);

    // R2: a producer in write-back alone never stalls
    a_r2_wb_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_reg_we && !mem_reg_we) |-> !stall);
endmodule

// File: rtl/hzc_fwd.sv
module hzc_fwd
    import hzc_pkg::*;
#(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input  logic                     fwd_en,
    input  logic [NSRC-1:0][RW-1:0]  ex_src,
    input  logic [RW-1:0]            mem_rd,
    input  logic                     mem_reg_we,
    input  logic [RW-1:0]            wb_rd,
    input  logic                     wb_reg_we,
    output opnd_src_e [NSRC-1:0]     sel
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    for (genvar k = 0; k < NSRC; k++) begin : g_opnd
        always_comb begin
            if (!fwd_en || ex_src[k] == ZERO_REG) begin
                sel[k] = SRC_RF;
            end else if (mem_reg_we && mem_rd == ex_src[k]) begin
                sel[k] = SRC_EXMEM;
            end else if (wb_reg_we && wb_rd == ex_src[k]) begin
                sel[k] = SRC_MEMWB;
            end else begin
                sel[k] = SRC_RF;
            end
        end
    end
endmodule

// File: rtl/hzc_branch_fsm.sv
module hzc_branch_fsm
    import hzc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stall,
    input  br_pol_e  policy,
    input  logic     id_is_branch,
    input  logic     id_br_taken,
    output logic     pc_we,
    output logic     ifid_we,
    output logic     idex_bubble,
    output logic     ifid_flush,
    output next_pc_e pc_sel
);
    br_state_e state_q, state_d;
    logic      taken_q;
    logic      resolve;

    assign resolve = (state_q == ST_RUN) && id_is_branch && !stall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            taken_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (resolve) begin
                taken_q <= id_br_taken;
            end
        end
    end

    always_comb begin
        state_d     = ST_RUN;
        pc_we       = !stall;
        ifid_we     = !stall;
        idex_bubble = stall;
        ifid_flush  = 1'b0;
        pc_sel      = NXT_SEQ;
        unique case (state_q)
            ST_RUN: begin
                if (resolve) begin
                    case (policy)
                        POL_NOT_TAKEN: begin
                            if (id_br_taken) begin
                                ifid_flush = 1'b1;
                                pc_sel     = NXT_TARGET;
                            end
                        end
                        POL_TAKEN: begin
                            ifid_flush = 1'b1;
                            pc_sel     = NXT_TARGET;
                            state_d    = ST_VERIFY;
                        end
                        default: begin
                            ifid_flush = 1'b1;
                            pc_sel     = id_br_taken ? NXT_TARGET : NXT_FALLTHRU;
                        end
                    endcase
                end
            end
            ST_VERIFY: begin
                if (!taken_q) begin
                    pc_we       = 1'b1;
                    ifid_we     = 1'b1;
                    idex_bubble = 1'b0;
                    ifid_flush  = 1'b1;
                    pc_sel      = NXT_FALLTHRU;
                end
            end
        endcase
    end

    // R9: the verify cycle only follows a predict-taken resolution
    a_r9_verify_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VERIFY) |-> $past(id_is_branch && policy == POL_TAKEN));

    // R10: a stalled branch takes no branch action
    a_r10_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stall) |-> (!ifid_flush && pc_sel == NXT_SEQ));

    // R7: any redirect squashes the fetch slot
    a_r7_redirect_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel != NXT_SEQ) |-> ifid_flush);

    // R2: a bubble always comes with a frozen front end
    a_r2_bubble_holds: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> (!pc_we && !ifid_we));
endmodule

// File: rtl/hzc_top.sv
module hzc_top
    import hzc_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_en,
    input  logic [1:0]    br_policy,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_use_rs1,
    input  logic          id_use_rs2,
    input  logic          id_is_branch,
    input  logic          id_br_taken,
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_reg_we,
    input  logic          ex_mem_rd,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_reg_we,
    input  logic          mem_mem_rd,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_reg_we,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          ifid_flush,
    output logic          idex_bubble,
    output logic [1:0]    pc_sel,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          br_fwd_a,
    output logic          br_fwd_b
);
    localparam int NSRC = 2;

    logic                      stall;
    logic [NSRC-1:0]           br_fwd;
    opnd_src_e [NSRC-1:0]      ex_sel;
    next_pc_e                  nxt;

    hzc_stall #(.RW(RW), .NSRC(NSRC)) u_stall (
        .clk          (clk),
        .rst_n        (rst_n),
        .fwd_en       (fwd_en),
        .id_src       ({id_rs2, id_rs1}),
        .id_use       ({id_use_rs2, id_use_rs1}),
        .id_is_branch (id_is_branch),
        .ex_rd        (ex_rd),
        .ex_reg_we    (ex_reg_we),
        .ex_mem_rd    (ex_mem_rd),
        .mem_rd       (mem_rd),
        .mem_reg_we   (mem_reg_we),
        .mem_mem_rd   (mem_mem_rd),
        .stall        (stall),
        .br_fwd       (br_fwd)
    );

    hzc_fwd #(.RW(RW), .NSRC(NSRC)) u_fwd (
        .fwd_en     (fwd_en),
        .ex_src     ({ex_rs2, ex_rs1}),
        .mem_rd     (mem_rd),
        .mem_reg_we (mem_reg_we),
        .wb_rd      (wb_rd),
        .wb_reg_we  (wb_reg_we),
        .sel        (ex_sel)
    );

    hzc_branch_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall        (stall),
        .policy       (br_pol_e'(br_policy)),
        .id_is_branch (id_is_branch),
        .id_br_taken  (id_br_taken),
        .pc_we        (pc_we),
        .ifid_we      (ifid_we),
        .idex_bubble  (idex_bubble),
        .ifid_flush   (ifid_flush),
        .pc_sel       (nxt)
    );

    assign pc_sel   = nxt;
    assign fwd_a    = ex_sel[0];
    assign fwd_b    = ex_sel[1];
    assign br_fwd_a = br_fwd[0];
    assign br_fwd_b = br_fwd[1];

    // R6: with bypassing off, operands always come from the register file
    a_r6_nofwd_regfile: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (fwd_a == 2'd0 && fwd_b == 2'd0 && !br_fwd_a && !br_fwd_b));

    // R4: a bypassed branch operand never coincides with a non-branch decode
    a_r4_brfwd_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (br_fwd_a || br_fwd_b) |-> id_is_branch);
endmodule

// File: tb/hzc_top_tb_top.sv
module hzc_top_tb_top;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fwd_en;
    logic [1:0]    br_policy;
    logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic          id_use_rs1, id_use_rs2, id_is_branch, id_br_taken;
    logic          ex_reg_we, ex_mem_rd, mem_reg_we, mem_mem_rd, wb_reg_we;
    logic          pc_we, ifid_we, ifid_flush, idex_bubble, br_fwd_a, br_fwd_b;
    logic [1:0]    pc_sel, fwd_a, fwd_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    hzc_top #(.RW(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .br_policy(br_policy),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
        .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_reg_we(ex_reg_we),
        .ex_mem_rd(ex_mem_rd), .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
        .mem_mem_rd(mem_mem_rd), .wb_rd(wb_rd), .wb_reg_we(wb_reg_we),
        .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush),
        .idex_bubble(idex_bubble), .pc_sel(pc_sel), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b)
    );

    wire [11:0] act = {pc_we, ifid_we, idex_bubble, ifid_flush, pc_sel, fwd_a, fwd_b, br_fwd_a, br_fwd_b};

    function automatic logic [11:0] mk(input logic pw, input logic iw, input logic bub,
                                       input logic fl, input logic [1:0] sel,
                                       input logic [1:0] fa, input logic [1:0] fb,
                                       input logic ba, input logic bb);
        return {pw, iw, bub, fl, sel, fa, fb, ba, bb};
    endfunction

    localparam logic [11:0] RUN   = 12'b1100_0000_0000;
    localparam logic [11:0] STALL = 12'b0010_0000_0000;

    // monitor: pops one expected item per cycle, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [11:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s: actual=%b expected=%b", t, act, e);
            end
        end
    end

    task automatic idle();
        id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0;
        id_is_branch = 0; id_br_taken = 0;
        ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_reg_we = 0; ex_mem_rd = 0;
        mem_rd = '0; mem_reg_we = 0; mem_mem_rd = 0; wb_rd = '0; wb_reg_we = 0;
    endtask

    // driver: inputs already applied; push expectation and advance one cycle
    task automatic step(input logic [11:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fwd_en = 0; br_policy = 2'd0;
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        step(RUN, "R1 idle after reset");

        // R2 no bypassing
        idle(); id_rs1 = 5'd3; id_use_rs1 = 1; ex_rd = 5'd3; ex_reg_we = 1;
        step(STALL, "R2 execute producer");
        idle(); id_rs2 = 5'd3; id_use_rs2 = 1; mem_rd = 5'd3; mem_reg_we = 1;
        step(STALL, "R2 memory producer");
        idle(); id_rs1 = 5'd3; id_use_rs1 = 1; wb_rd = 5'd3; wb_reg_we = 1;
        step(RUN, "R2 write-back producer no stall");
        idle(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 5'd9; id_use_rs1 = 1;
        mem_rd = 5'd9; mem_reg_we = 1;
        step(STALL, "R2 R10 branch stalled without bypass");
        idle(); id_rs1 = 5'd0; id_use_rs1 = 1; ex_rd = 5'd0; ex_reg_we = 1;
        step(RUN, "R5 zero register no stall");

        // R3 full bypassing
        fwd_en = 1;
        idle(); id_rs2 = 5'd4; id_use_rs2 = 1; ex_rd = 5'd4; ex_reg_we = 1; ex_mem_rd = 1;
        step(STALL, "R3 load-use");
        idle(); id_rs2 = 5'd4; id_use_rs2 = 1; ex_rd = 5'd4; ex_reg_we = 1;
        step(RUN, "R3 ALU producer bypassed");

        // R4 branch in decode with bypassing
        br_policy = 2'd1;
        idle(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 5'd6; id_use_rs1 = 1;
        ex_rd = 5'd6; ex_reg_we = 1;
        step(STALL, "R4 R10 branch behind ALU");
        idle(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 5'd6; id_use_rs1 = 1;
        mem_rd = 5'd6; mem_reg_we = 1; mem_mem_rd = 1;
        step(STALL, "R4 R10 branch behind load in memory");
        idle(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 5'd6; id_use_rs1 = 1;
        mem_rd = 5'd6; mem_reg_we = 1;
        step(mk(1,1,0,1,2'd1,2'd0,2'd0,1,0), "R4 R8 branch bypass from memory, taken");

        // R6 execute operand selects
        idle(); ex_rs1 = 5'd7; ex_rs2 = 5'd7; mem_rd = 5'd7; mem_reg_we = 1; wb_rd = 5'd7; wb_reg_we = 1;
        step(mk(1,1,0,0,2'd0,2'd1,2'd1,0,0), "R6 memory match has priority");
        idle(); ex_rs1 = 5'd7; ex_rs2 = 5'd8; mem_rd = 5'd2; mem_reg_we = 1; wb_rd = 5'd8; wb_reg_we = 1;
        step(mk(1,1,0,0,2'd0,2'd0,2'd2,0,0), "R6 write-back match");
        idle(); ex_rs1 = 5'd0; mem_rd = 5'd0; mem_reg_we = 1;
        step(RUN, "R5 zero register not bypassed");
        fwd_en = 0;
        idle(); ex_rs1 = 5'd7; ex_rs2 = 5'd7; mem_rd = 5'd7; mem_reg_we = 1;
        step(RUN, "R6 selects zero without bypass");
        fwd_en = 1;

        // R7 squash policy
        br_policy = 2'd0;
        idle(); id_is_branch = 1; id_br_taken = 0;
        step(mk(1,1,0,1,2'd2,2'd0,2'd0,0,0), "R7 squash not taken");
        idle(); id_is_branch = 1; id_br_taken = 1;
        step(mk(1,1,0,1,2'd1,2'd0,2'd0,0,0), "R7 squash taken");
        br_policy = 2'd3;
        idle(); id_is_branch = 1; id_br_taken = 0;
        step(mk(1,1,0,1,2'd2,2'd0,2'd0,0,0), "R7 code 3 acts as squash");

        // R8 predict not-taken
        br_policy = 2'd1;
        idle(); id_is_branch = 1; id_br_taken = 0;
        step(RUN, "R8 not taken continues");

        // R9 predict taken
        br_policy = 2'd2;
        idle(); id_is_branch = 1; id_br_taken = 1;
        step(mk(1,1,0,1,2'd1,2'd0,2'd0,0,0), "R9 taken redirect");
        idle();
        step(RUN, "R9 taken verify quiet");
        idle(); id_is_branch = 1; id_br_taken = 0;
        step(mk(1,1,0,1,2'd1,2'd0,2'd0,0,0), "R9 not-taken first redirect");
        idle();
        step(mk(1,1,0,1,2'd2,2'd0,2'd0,0,0), "R9 not-taken fall-through repair");
        idle();
        step(RUN, "R9 back to normal flow");

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule